// File: doc/BRIEF.md
# Floppy controller host glue

This block sits between an 8-bit processor I/O bus and a floppy disk controller that moves its data by DMA. The processor writes one output port to switch drive motors and another to set a general control bit, and it reads a third port to see every control latch at once. Decoding of the port number into a strobe is done upstream; the block receives a write strobe, a read strobe and the 3-bit port number with each.

The block holds one motor-on latch per drive for four drives. A configuration pin ties the motor of drive 1 to the drive-0 latch, so that software written for a single motor bit keeps working. The direction of every DMA transfer is taken directly from the controller's write-enable output, so software never programs it. The controller's completion signal goes either to a pollable flag or to an interrupt request, chosen by a configuration pin.

Each DMA request has to be acknowledged within one byte time of the disk (16 us at the double-density high rate, 64 us at the slowest single-density rate). A small state machine with states DMA_IDLE, DMA_WAIT and DMA_LATE times every request: DMA_IDLE goes to DMA_WAIT when a request is seen; DMA_WAIT returns to DMA_IDLE on acknowledge and goes to DMA_LATE when the limit runs out; DMA_LATE returns to DMA_IDLE when the request drops or is acknowledged. Entering DMA_LATE sets a sticky overrun flag that software sees in the readback byte.

Top module: `fdc_glue`

## Requirements
- R1: A write strobe with port number 2 loads data bits [3:0] into the four motor latches; with the shared pin low, motor_on[3:0] shows the new value from the next clock cycle.
- R2: With cfg_shared_motor high, motor_on[1] equals motor_on[0] (the drive-0 latch), while the readback byte still shows all four latches as written.
- R3: A write strobe with port number 1 loads data bit 3 into the control latch, output ctrl_bit, from the next cycle; other data bits do not affect it.
- R4: A read strobe with port number 7 drives data_out with {2'b00, overrun, control latch, motor latches [3:0]} and raises data_oe in the same cycle; at all other times data_out is 0 and data_oe is low.
- R5: While dma_ack is high, fdc_we high raises dma_rd_mem (memory to controller) and fdc_we low raises dma_wr_mem (controller to memory); with dma_ack low both are low.
- R6: With cfg_irq_route high, irq_req follows fdc_int one cycle later and done_flag stays low; with it low, done_flag follows fdc_int one cycle later and irq_req stays low.
- R7: The acknowledge limit is FAST_CYC cycles (default 800, 16 us at 50 MHz) with cfg_slow_rate low and SLOW_CYC cycles (default 3200, 64 us) with it high, counted from the first cycle a request is sampled.
- R8: A request not acknowledged within the limit sets a sticky overrun flag (readback bit 5); it stays set across later good transfers and is cleared by any write to port 1.
- R9: After reset all motor latches, the control latch and the overrun flag are zero, and irq_req and done_flag are low.
- R10: Write strobes to port numbers other than 1 and 2 change no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_strobe | input | 1 | Decoded output-port write strobe, one cycle |
| out_port | input | 3 | Port number of the write |
| in_strobe | input | 1 | Decoded input-port read strobe |
| in_port | input | 3 | Port number of the read |
| data_in | input | 8 | Data bus from the processor |
| data_out | output | 8 | Readback data, zero when not driven |
| data_oe | output | 1 | High while the block drives the data bus |
| cfg_shared_motor | input | 1 | Drive 1 motor follows the drive-0 latch |
| cfg_irq_route | input | 1 | 1: completion to irq_req, 0: to done_flag |
| cfg_slow_rate | input | 1 | Selects the slow byte-time limit |
| fdc_we | input | 1 | Controller write-enable output |
| fdc_int | input | 1 | Controller completion output |
| dma_req | input | 1 | Controller DMA request |
| dma_ack | input | 1 | DMA acknowledge from the DMA engine |
| motor_on | output | 4 | Motor-on lines to the drives |
| ctrl_bit | output | 1 | Latched control bit |
| dma_rd_mem | output | 1 | DMA cycle reads memory into the controller |
| dma_wr_mem | output | 1 | DMA cycle writes controller data to memory |
| done_flag | output | 1 | Pollable completion flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions take for granted that the configuration pins change only while the bus is idle, that a write strobe lasts a single cycle, and that dma_ack is only raised while dma_req is high. The bench changes configuration between scenarios with no strobe active, drives every strobe for exactly one cycle between falling edges, and raises acknowledge only on a pending request. Overrun timing is probed with wide margins on each side of the limit rather than at the exact boundary cycle.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;

    typedef enum logic [1:0] {
        DMA_IDLE = 2'd0,
        DMA_WAIT = 2'd1,
        DMA_LATE = 2'd2
    } dma_state_t;

    localparam logic [2:0] PORT_CTRL  = 3'd1;
    localparam logic [2:0] PORT_MOTOR = 3'd2;
    localparam logic [2:0] PORT_READ  = 3'd7;

    typedef struct packed {
        logic [1:0] zero;
        logic       overrun;
        logic       ctrl;
        logic [3:0] motor;
    } readback_t;

endpackage

// File: rtl/fdc_glue_regs.sv
module fdc_glue_regs
    import fdc_glue_pkg::*;
#(
    parameter int DRIVES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [2:0]        wr_port,
    input  logic [DRIVES-1:0] wr_data,
    input  logic              ctrl_data,
    output logic [DRIVES-1:0] motor_q,
    output logic              ctrl_q,
    output logic              ctrl_wr
);

    logic motor_wr;

    always_comb begin
        motor_wr = wr_stb && (wr_port == PORT_MOTOR);
        ctrl_wr  = wr_stb && (wr_port == PORT_CTRL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            motor_q <= '0;
            ctrl_q  <= 1'b0;
        end else begin
            if (motor_wr) motor_q <= wr_data;
            if (ctrl_wr)  ctrl_q  <= ctrl_data;
        end
    end

endmodule

// File: rtl/fdc_glue_dma.sv
module fdc_glue_dma
    import fdc_glue_pkg::*;
#(
    parameter int FAST_CYC = 800,
    parameter int SLOW_CYC = 3200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_rate,
    input  logic req,
    input  logic ack,
    input  logic clr_ovr,
    output logic overrun
);

    localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    dma_state_t      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [CW-1:0]   last_cnt;
    logic            expire;

    always_comb begin
        last_cnt = slow_rate ? CW'(SLOW_CYC - 1) : CW'(FAST_CYC - 1);
        expire   = 1'b0;
        state_d  = state_q;
        cnt_d    = cnt_q;
        unique case (state_q)
            DMA_IDLE: begin
                cnt_d = '0;
                if (req) state_d = DMA_WAIT;
            end
            DMA_WAIT: begin
                if (ack) begin
                    state_d = DMA_IDLE;
                end else if (cnt_q >= last_cnt) begin
                    state_d = DMA_LATE;
                    expire  = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            DMA_LATE: begin
                if (ack || !req) state_d = DMA_IDLE;
            end
            default: state_d = DMA_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DMA_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       overrun <= 1'b0;
        else if (expire)  overrun <= 1'b1;
        else if (clr_ovr) overrun <= 1'b0;
    end

endmodule

// File: rtl/fdc_glue_route.sv
module fdc_glue_route (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_route,
    input  logic fdc_int,
    input  logic fdc_we,
    input  logic dma_ack,
    output logic done_flag,
    output logic irq_req,
    output logic dma_rd_mem,
    output logic dma_wr_mem
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req   <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            irq_req   <= fdc_int && irq_route;
            done_flag <= fdc_int && !irq_route;
        end
    end

    always_comb begin
        dma_rd_mem = dma_ack && fdc_we;
        dma_wr_mem = dma_ack && !fdc_we;
    end

endmodule

// File: rtl/fdc_glue.sv
module fdc_glue
    import fdc_glue_pkg::*;
#(
    parameter int FAST_CYC = 800,
    parameter int SLOW_CYC = 3200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       out_strobe,
    input  logic [2:0] out_port,
    input  logic       in_strobe,
    input  logic [2:0] in_port,
    input  logic [7:0] data_in,
    output logic [7:0] data_out,
    output logic       data_oe,
    input  logic       cfg_shared_motor,
    input  logic       cfg_irq_route,
    input  logic       cfg_slow_rate,
    input  logic       fdc_we,
    input  logic       fdc_int,
    input  logic       dma_req,
    input  logic       dma_ack,
    output logic [3:0] motor_on,
    output logic       ctrl_bit,
    output logic       dma_rd_mem,
    output logic       dma_wr_mem,
    output logic       done_flag,
    output logic       irq_req
);

    localparam int DRIVES = 4;

    logic [DRIVES-1:0] motor_q;
    logic              ctrl_wr;
    logic              overrun;
    logic              unused_hi;
    readback_t         rb;

    assign unused_hi = ^data_in[7:4];

    fdc_glue_regs #(.DRIVES(DRIVES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (out_strobe),
        .wr_port  (out_port),
        .wr_data  (data_in[DRIVES-1:0]),
        .ctrl_data(data_in[3]),
        .motor_q  (motor_q),
        .ctrl_q   (ctrl_bit),
        .ctrl_wr  (ctrl_wr)
    );

    fdc_glue_dma #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_rate(cfg_slow_rate),
        .req      (dma_req),
        .ack      (dma_ack),
        .clr_ovr  (ctrl_wr),
        .overrun  (overrun)
    );

    fdc_glue_route u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_route (cfg_irq_route),
        .fdc_int   (fdc_int),
        .fdc_we    (fdc_we),
        .dma_ack   (dma_ack),
        .done_flag (done_flag),
        .irq_req   (irq_req),
        .dma_rd_mem(dma_rd_mem),
        .dma_wr_mem(dma_wr_mem)
    );

    generate
        for (genvar d = 0; d < DRIVES; d++) begin : g_motor
            if (d == 1) begin : g_pair
                assign motor_on[d] = cfg_shared_motor ? motor_q[0] : motor_q[d];
            end else begin : g_solo
                assign motor_on[d] = motor_q[d];
            end
        end
    endgenerate

    always_comb begin
        rb.zero    = 2'b00;
        rb.overrun = overrun;
        rb.ctrl    = ctrl_bit;
        rb.motor   = motor_q;
        data_oe    = in_strobe && (in_port == PORT_READ);
        data_out   = data_oe ? rb : 8'h00;
    end

endmodule

// File: rtl/fdc_glue_chk.sv
module fdc_glue_chk
    import fdc_glue_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       out_strobe,
    input logic [2:0] out_port,
    input logic       in_strobe,
    input logic [2:0] in_port,
    input logic [7:0] data_in,
    input logic [7:0] data_out,
    input logic       data_oe,
    input logic       cfg_shared_motor,
    input logic       dma_req,
    input logic       dma_ack,
    input logic [3:0] motor_on,
    input logic       ctrl_bit,
    input logic       dma_rd_mem,
    input logic       dma_wr_mem,
    input logic       done_flag,
    input logic       irq_req,
    input logic       overrun
);

    a_r1_motor_load: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && out_port == PORT_MOTOR && !cfg_shared_motor)
        |=> (cfg_shared_motor || motor_on == $past(data_in[3:0])));

    a_r2_shared_pair: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shared_motor |-> (motor_on[1] == motor_on[0]));

    a_r3_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && out_port == PORT_CTRL) |=> (ctrl_bit == $past(data_in[3])));

    a_r4_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_strobe && in_port == PORT_READ) |-> (!data_oe && data_out == 8'h00));

    a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_rd_mem, dma_wr_mem}) && (dma_ack || !(dma_rd_mem || dma_wr_mem)));

    a_r6_one_route: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_req && done_flag));

    a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(dma_req) && !$past(dma_ack)));

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(out_strobe && out_port == PORT_CTRL)) |=> overrun);

endmodule

bind fdc_glue fdc_glue_chk u_chk (.*);

// File: tb/fdc_glue_tb.sv
`timescale 1ns/1ps
module fdc_glue_tb;

    localparam int FAST = 800;
    localparam int SLOW = 3200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       out_strobe = 1'b0;
    logic [2:0] out_port = 3'd0;
    logic       in_strobe = 1'b0;
    logic [2:0] in_port = 3'd0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       data_oe;
    logic       cfg_shared_motor = 1'b0;
    logic       cfg_irq_route = 1'b0;
    logic       cfg_slow_rate = 1'b0;
    logic       fdc_we = 1'b0;
    logic       fdc_int = 1'b0;
    logic       dma_req = 1'b0;
    logic       dma_ack = 1'b0;
    logic [3:0] motor_on;
    logic       ctrl_bit;
    logic       dma_rd_mem;
    logic       dma_wr_mem;
    logic       done_flag;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fdc_glue u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] port, input logic [7:0] val);
        @(negedge clk);
        out_strobe = 1'b1; out_port = port; data_in = val;
        @(negedge clk);
        out_strobe = 1'b0; data_in = 8'h00;
    endtask

    task automatic rd(output logic [7:0] val, output logic oe);
        @(negedge clk);
        in_strobe = 1'b1; in_port = 3'd7;
        #2;
        val = data_out; oe = data_oe;
        @(negedge clk);
        in_strobe = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v; logic oe;
        rd(v, oe);
        check("R9 readback", {24'd0, v}, 32'h00);
        check("R9 outputs", {motor_on, ctrl_bit, irq_req, done_flag}, 7'd0);
        check("R4 oe on read", oe, 1);
        #1 check("R4 idle bus", {data_oe, data_out}, 9'd0);
    endtask

    task automatic t_motor;
        logic [7:0] v; logic oe;
        wr(3'd2, 8'hF5);
        check("R1 motor 5", motor_on, 4'h5);
        wr(3'd2, 8'h0A);
        check("R1 motor A", motor_on, 4'hA);
        rd(v, oe);
        check("R4 readback motor", v, 8'h0A);
        wr(3'd3, 8'hFF); wr(3'd0, 8'hFF); wr(3'd7, 8'hFF);
        rd(v, oe);
        check("R10 other ports ignored", {v, motor_on, ctrl_bit}, {8'h0A, 4'hA, 1'b0});
    endtask

    task automatic t_shared;
        logic [7:0] v; logic oe;
        @(negedge clk); cfg_shared_motor = 1'b1;
        wr(3'd2, 8'h01);
        check("R2 shared on", motor_on, 4'h3);
        wr(3'd2, 8'h02);
        check("R2 shared drive1 off", motor_on, 4'h0);
        rd(v, oe);
        check("R2 raw latches", v, 8'h02);
        @(negedge clk); cfg_shared_motor = 1'b0;
        #1 check("R2 shared off", motor_on, 4'h2);
    endtask

    task automatic t_ctrl;
        logic [7:0] v; logic oe;
        wr(3'd1, 8'h08);
        check("R3 ctrl set", ctrl_bit, 1);
        wr(3'd1, 8'hF7);
        check("R3 ctrl clear other bits", ctrl_bit, 0);
        wr(3'd1, 8'h08);
        rd(v, oe);
        check("R4 readback ctrl", v, 8'h12);
    endtask

    task automatic t_dir;
        @(negedge clk); fdc_we = 1'b1; #1;
        check("R5 no ack", {dma_rd_mem, dma_wr_mem}, 2'b00);
        dma_req = 1'b1; dma_ack = 1'b1; #1;
        check("R5 we high", {dma_rd_mem, dma_wr_mem}, 2'b10);
        fdc_we = 1'b0; #1;
        check("R5 we low", {dma_rd_mem, dma_wr_mem}, 2'b01);
        @(negedge clk); dma_ack = 1'b0; dma_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_route;
        @(negedge clk); cfg_irq_route = 1'b1; fdc_int = 1'b1;
        @(negedge clk);
        check("R6 irq path", {irq_req, done_flag}, 2'b10);
        fdc_int = 1'b0;
        @(negedge clk);
        check("R6 irq drop", {irq_req, done_flag}, 2'b00);
        cfg_irq_route = 1'b0; fdc_int = 1'b1;
        @(negedge clk);
        check("R6 flag path", {irq_req, done_flag}, 2'b01);
        fdc_int = 1'b0;
        @(negedge clk);
    endtask

    task automatic dma_xfer(input int wait_cyc);
        @(negedge clk); dma_req = 1'b1;
        repeat (wait_cyc) @(negedge clk);
        dma_ack = 1'b1;
        @(negedge clk); dma_ack = 1'b0; dma_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_overrun;
        logic [7:0] v; logic oe;
        dma_xfer(FAST / 2);
        rd(v, oe);
        check("R7 fast in time", v[5], 0);
        dma_xfer(FAST + 20);
        rd(v, oe);
        check("R8 overrun set", v[5], 1);
        dma_xfer(4);
        rd(v, oe);
        check("R8 sticky", v[5], 1);
        wr(3'd1, 8'h00);
        rd(v, oe);
        check("R8 cleared by ctrl write", v, 8'h02);
        @(negedge clk); cfg_slow_rate = 1'b1;
        dma_xfer(FAST + 400);
        rd(v, oe);
        check("R7 slow in time", v[5], 0);
        dma_xfer(SLOW + 20);
        rd(v, oe);
        check("R7 slow overrun", v[5], 1);
        @(negedge clk); cfg_slow_rate = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_motor();
        t_shared();
        t_ctrl();
        t_dir();
        t_route();
        t_overrun();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule